// File: doc/BRIEF.md
# Path-Locking Switch with Round-Robin Output Arbitration

This block is one switch of a small hierarchical on-chip network. Masters present transactions on full-duplex input ports. Every output port leads toward a memory section or toward another switch. The upper bits of each transaction's address pick the output port. Each output port has its own equal-priority round-robin arbiter.

The winning master keeps the output port for the whole transaction. For a write, the port is held until the last request word has been accepted. For a read, the port is also held through the response that comes back on the return path. Masters that lose arbitration keep requesting and try again when the port is freed.

The output side has a ready input, and the response side is word-per-cycle. Because of this, an output port of one instance can feed an input port of a second instance to build a two-level hierarchy.

Top module: `lockpath_switch`

## Requirements
- R1: Each link moves at most one word per cycle in each direction. A multi-word request whose output port is free and ready completes at one word per cycle, with no gap after its first word.
- R2: The destination port is chosen from the top TW address bits (the tag). Port 0 covers tags 0 to 3, port 1 covers tags 4 to 7, and port 2 covers tags 8 to 11. The lowest-numbered matching port wins.
- R3: An address whose tag matches no range goes to the highest-numbered output port.
- R4: A request to a free port is granted at the first clock edge. The first word is therefore accepted one cycle after the request appears, whether or not there was contention.
- R5: Each port grants among its waiting inputs in round-robin order. The search starts at the input after the last owner, and the pointer moves only when the port is released.
- R6: A losing input waits, with in_rdy low, until the port is released. A write releases the port at the clock edge that accepts its last request word (in_wr=1, in_last=1).
- R7: A read (in_wr=0) keeps the port after its last request word, until the response word with rsp_last=1 has been delivered. Response words reach only the owning input.
- R8: While out_rdy of the owned port is low, the word stays on the output with out_vld high, and in_rdy of the owner stays low.
- R9: During reset, no output port is valid, no input is ready, and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | N_IN | Request word valid, one bit per input |
| in_addr | input | N_IN*AW | Request address per input |
| in_data | input | N_IN*DW | Request data per input |
| in_wr | input | N_IN | 1 = write, 0 = read |
| in_last | input | N_IN | Last request word of the transaction |
| in_rdy | output | N_IN | Request word accepted this cycle |
| in_rsp_vld | output | N_IN | Response word valid toward the input |
| in_rsp_data | output | N_IN*DW | Response data toward the input |
| in_rsp_last | output | N_IN | Last response word |
| out_vld | output | N_OUT | Request word valid on the output port |
| out_addr | output | N_OUT*AW | Forwarded address |
| out_data | output | N_OUT*DW | Forwarded data |
| out_wr | output | N_OUT | Forwarded write flag |
| out_last | output | N_OUT | Forwarded last flag |
| out_rdy | input | N_OUT | Downstream accepts the word |
| rsp_vld | input | N_OUT | Response word valid from downstream |
| rsp_data | input | N_OUT*DW | Response data from downstream |
| rsp_last | input | N_OUT | Last response word from downstream |

## Verification
The assertions assume the following about the inputs:
- A master holds in_vld and its word fields steady until in_rdy is high.
- A master does not start a new transaction while it is still waiting for a read response.
- Downstream raises rsp_vld only after the read's last request word has been accepted, and ends every response with rsp_last.

The bench keeps within these assumptions. Its masters change their fields only after a handshake edge, and each master waits for the full read response before it issues again. Its memory models answer each read with two words, starting two cycles after the read's final request word.

// File: rtl/lockpath_switch.sv
module lockpath_switch #(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter logic [N_OUT*TW-1:0] RNG_LO = {4'h8, 4'h4, 4'h0},
  parameter logic [N_OUT*TW-1:0] RNG_HI = {4'hB, 4'h7, 4'h3}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     in_vld,
  input  logic [N_IN*AW-1:0]  in_addr,
  input  logic [N_IN*DW-1:0]  in_data,
  input  logic [N_IN-1:0]     in_wr,
  input  logic [N_IN-1:0]     in_last,
  output logic [N_IN-1:0]     in_rdy,
  output logic [N_IN-1:0]     in_rsp_vld,
  output logic [N_IN*DW-1:0]  in_rsp_data,
  output logic [N_IN-1:0]     in_rsp_last,
  output logic [N_OUT-1:0]    out_vld,
  output logic [N_OUT*AW-1:0] out_addr,
  output logic [N_OUT*DW-1:0] out_data,
  output logic [N_OUT-1:0]    out_wr,
  output logic [N_OUT-1:0]    out_last,
  input  logic [N_OUT-1:0]    out_rdy,
  input  logic [N_OUT-1:0]    rsp_vld,
  input  logic [N_OUT*DW-1:0] rsp_data,
  input  logic [N_OUT-1:0]    rsp_last
);
  localparam int IW = (N_IN  > 1) ? $clog2(N_IN)  : 1;
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  logic [N_OUT-1:0] busy, rsp_ph, hs;
  logic [IW-1:0]    owner [N_OUT];
  logic [IW-1:0]    ptr   [N_OUT];
  logic [IW-1:0]    pick  [N_OUT];
  logic [N_IN-1:0]  req   [N_OUT];
  logic [OW-1:0]    dst   [N_IN];
  logic [N_IN-1:0]  holds;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [TW-1:0]    tag;
    logic [N_OUT-1:0] own_v;
    assign tag = in_addr[i*AW+AW-1 -: TW];
    always_comb begin
      dst[i] = OW'(N_OUT-1);
      for (int p = N_OUT-1; p >= 0; p--)
        if (tag >= RNG_LO[p*TW +: TW] && tag <= RNG_HI[p*TW +: TW]) dst[i] = OW'(p);
    end
    always_comb
      for (int p = 0; p < N_OUT; p++) own_v[p] = busy[p] && owner[p] == IW'(i);
    assign holds[i] = |own_v;

    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(own_v) <= 1);
  end

  always_comb
    for (int p = 0; p < N_OUT; p++)
      for (int i = 0; i < N_IN; i++)
        req[p][i] = in_vld[i] && dst[i] == OW'(p) && !holds[i];

  always_comb begin
    in_rdy = '0;
    in_rsp_vld = '0;
    in_rsp_data = '0;
    in_rsp_last = '0;
    for (int p = 0; p < N_OUT; p++)
      if (busy[p]) begin
        if (!rsp_ph[p]) in_rdy[owner[p]] = out_rdy[p];
        else begin
          in_rsp_vld[owner[p]] = rsp_vld[p];
          in_rsp_last[owner[p]] = rsp_last[p];
          in_rsp_data[int'(owner[p])*DW +: DW] = rsp_data[p*DW +: DW];
        end
      end
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_out
    logic [IW-1:0] nxt;
    int idx;
    logic found;

    always_comb begin
      pick[p] = ptr[p];
      found = 1'b0;
      idx = 0;
      for (int k = 0; k < N_IN; k++) begin
        idx = (int'(ptr[p]) + k) % N_IN;
        if (!found && req[p][idx]) begin
          pick[p] = IW'(idx);
          found = 1'b1;
        end
      end
    end

    assign nxt = (owner[p] == IW'(N_IN-1)) ? '0 : owner[p] + 1'b1;
    assign out_vld[p]            = busy[p] & ~rsp_ph[p] & in_vld[owner[p]];
    assign out_addr[p*AW +: AW]  = in_addr[int'(owner[p])*AW +: AW];
    assign out_data[p*DW +: DW]  = in_data[int'(owner[p])*DW +: DW];
    assign out_wr[p]             = in_wr[owner[p]];
    assign out_last[p]           = in_last[owner[p]];
    assign hs[p]                 = out_vld[p] & out_rdy[p];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        busy[p]   <= 1'b0;
        rsp_ph[p] <= 1'b0;
        owner[p]  <= '0;
        ptr[p]    <= '0;
      end else if (!busy[p]) begin
        if (|req[p]) begin
          busy[p]   <= 1'b1;
          rsp_ph[p] <= 1'b0;
          owner[p]  <= pick[p];
        end
      end else if (!rsp_ph[p]) begin
        if (hs[p] && out_last[p]) begin
          if (out_wr[p]) begin
            busy[p] <= 1'b0;
            ptr[p]  <= nxt;
          end else rsp_ph[p] <= 1'b1;
        end
      end else if (rsp_vld[p] && rsp_last[p]) begin
        busy[p]   <= 1'b0;
        rsp_ph[p] <= 1'b0;
        ptr[p]    <= nxt;
      end

    // R6
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] && $past(busy[p]) |-> $stable(owner[p]));
    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr[p]) |-> $fell(busy[p]));
    // R6
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] && !rsp_ph[p] && hs[p] && out_last[p] && out_wr[p] |=> !busy[p]);
    // R7
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] && !rsp_ph[p] && hs[p] && out_last[p] && !out_wr[p] |=> busy[p] && rsp_ph[p]);
  end
endmodule

// File: tb/sim_lockpath_switch.sv
module sim_lockpath_switch;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [2:0] in_vld, in_wr, in_last, in_rdy, in_rsp_vld, in_rsp_last;
  logic [47:0] in_addr, in_data, in_rsp_data;
  logic [2:0] out_vld, out_wr, out_last, out_rdy, rsp_vld, rsp_last;
  logic [47:0] out_addr, out_data, rsp_data;

  logic m_vld [3], m_wr [3], m_last [3];
  logic [15:0] m_addr [3], m_data [3];
  logic r_vld [3], r_last [3];
  logic [15:0] r_data [3], r_addr [3];
  int r_wt [3];
  logic [2:0] ordy = 3'b111;

  always_comb
    for (int i = 0; i < 3; i++) begin
      in_vld[i] = m_vld[i]; in_wr[i] = m_wr[i]; in_last[i] = m_last[i];
      in_addr[i*16 +: 16] = m_addr[i]; in_data[i*16 +: 16] = m_data[i];
      rsp_vld[i] = r_vld[i]; rsp_last[i] = r_last[i]; rsp_data[i*16 +: 16] = r_data[i];
    end
  assign out_rdy = ordy;

  lockpath_switch u0 (.clk, .rst_n, .in_vld, .in_addr, .in_data, .in_wr, .in_last, .in_rdy,
    .in_rsp_vld, .in_rsp_data, .in_rsp_last, .out_vld, .out_addr, .out_data, .out_wr,
    .out_last, .out_rdy, .rsp_vld, .rsp_data, .rsp_last);

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [33:0] q0 [$], q1 [$], q2 [$];

  task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s act %0h exp %0h", r, act, exp); end
  endtask

  function automatic logic [15:0] dat(int i, int k, logic [7:0] a);
    return {4'(i), 4'(k), a};
  endfunction
  function automatic logic [15:0] rsp_f(logic [15:0] a, int k);
    return a ^ (16'hC300 + 16'(k));
  endfunction
  function automatic logic [33:0] wrd(logic [15:0] a, logic [15:0] d, bit wr, bit last);
    return {a, d, wr, last};
  endfunction
  task automatic push(int p, logic [33:0] w);
    case (p) 0: q0.push_back(w); 1: q1.push_back(w); default: q2.push_back(w); endcase
  endtask

  // monitor: scoreboard compare per output port, and read-response trigger
  initial forever begin
    @(negedge clk);
    for (int p = 0; p < 3; p++)
      if (rst_n && out_vld[p] && out_rdy[p]) begin
        logic [33:0] act, exp;
        int n;
        act = {out_addr[p*16 +: 16], out_data[p*16 +: 16], out_wr[p], out_last[p]};
        n = (p == 0) ? q0.size() : (p == 1) ? q1.size() : q2.size();
        if (n == 0) chk(0, $sformatf("R2 port %0d unexpected word", p), act, 0);
        else begin
          exp = (p == 0) ? q0.pop_front() : (p == 1) ? q1.pop_front() : q2.pop_front();
          chk(act == exp, $sformatf("R2 R5 R6 port %0d word", p), act, exp);
        end
        if (!out_wr[p] && out_last[p]) begin r_addr[p] = out_addr[p*16 +: 16]; r_wt[p] = 2; end
      end
  end

  // memory responders: two response words per read
  initial forever begin
    @(posedge clk); #1;
    for (int p = 0; p < 3; p++)
      if (r_vld[p]) begin
        if (r_last[p]) begin r_vld[p] = 0; r_last[p] = 0; end
        else begin r_data[p] = rsp_f(r_addr[p], 1); r_last[p] = 1; end
      end else if (r_wt[p] == 1) begin
        r_wt[p] = 0; r_vld[p] = 1; r_last[p] = 0; r_data[p] = rsp_f(r_addr[p], 0);
      end else if (r_wt[p] > 1) r_wt[p]--;
  end

  task automatic mtx(int i, logic [15:0] a, int n, bit wr, output int wt);
    wt = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      m_vld[i] = 1; m_addr[i] = a; m_data[i] = dat(i, k, a[7:0]); m_wr[i] = wr; m_last[i] = (k == n-1);
      do begin @(negedge clk); if (!in_rdy[i]) wt++; end while (!in_rdy[i]);
    end
    @(posedge clk); #1;
    m_vld[i] = 0; m_last[i] = 0;
    if (!wr) begin
      int got = 0;
      while (got < 2) begin
        @(negedge clk);
        if (in_rsp_vld[i]) begin
          chk(in_rsp_data[i*16 +: 16] == rsp_f(a, got), "R7 response data", in_rsp_data[i*16 +: 16], rsp_f(a, got));
          chk(in_rsp_last[i] == (got == 1), "R7 response last", in_rsp_last[i], got == 1);
          chk((in_rsp_vld & ~(3'b1 << i)) == 0, "R7 response only to owner", in_rsp_vld, 3'b1 << i);
          got++;
        end
      end
    end
  endtask

  task automatic drained(string r);
    repeat (2) @(negedge clk);
    chk(q0.size() + q1.size() + q2.size() == 0, r, q0.size() + q1.size() + q2.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired act 0 exp 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int w0, w1, w2;
    for (int i = 0; i < 3; i++) begin
      m_vld[i] = 0; m_wr[i] = 0; m_last[i] = 0; m_addr[i] = 0; m_data[i] = 0;
      r_vld[i] = 0; r_last[i] = 0; r_data[i] = 0; r_addr[i] = 0; r_wt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    chk(out_vld == 0 && in_rdy == 0 && in_rsp_vld == 0, "R9 reset outputs", {out_vld, in_rdy, in_rsp_vld}, 0);
    @(posedge clk); #1 rst_n = 1;

    // R1 R4: three-word write, free port 1
    for (int k = 0; k < 3; k++) push(1, wrd(16'h4010, dat(0, k, 8'h10), 1, k == 2));
    mtx(0, 16'h4010, 3, 1, w0);
    chk(w0 == 1, "R1 R4 one wait cycle then word per cycle", w0, 1);
    drained("R2 port1 write delivered");

    // R2 R3: range routing and unmatched tag
    for (int k = 0; k < 2; k++) push(0, wrd(16'h0020, dat(1, k, 8'h20), 1, k == 1));
    push(2, wrd(16'h9000, dat(2, 0, 8'h00), 1, 1));
    fork
      mtx(1, 16'h0020, 2, 1, w1);
      mtx(2, 16'h9000, 1, 1, w2);
    join
    chk(w1 == 1 && w2 == 1, "R4 parallel ports no contention", {w1[7:0], w2[7:0]}, 16'h0101);
    push(2, wrd(16'hE000, dat(0, 0, 8'h00), 1, 1));
    mtx(0, 16'hE000, 1, 1, w0);
    drained("R3 unmatched tag to last port");

    // R7: read on port 0
    push(0, wrd(16'h1234, dat(0, 0, 8'h34), 0, 1));
    mtx(0, 16'h1234, 1, 0, w0);
    chk(w0 == 1, "R4 read grant delay", w0, 1);
    drained("R7 read request delivered");

    // R6 R7: read holds port 1 while a write waits
    push(1, wrd(16'h5000, dat(1, 0, 8'h00), 0, 1));
    push(1, wrd(16'h6000, dat(2, 0, 8'h00), 1, 1));
    fork
      mtx(1, 16'h5000, 1, 0, w1);
      mtx(2, 16'h6000, 1, 1, w2);
    join
    chk(w1 == 1, "R5 pointer past last owner", w1, 1);
    chk(w2 == 6, "R6 R7 loser waits through response", w2, 6);
    drained("R6 port1 order");

    // R5: round robin, pointer of port 0 at input 1
    for (int r = 0; r < 2; r++) begin
      push(0, wrd(16'h2000 + 16'(r) * 16'h100, dat(1, 0, 8'h00), 1, 1));
      push(0, wrd(16'h2000 + 16'(r) * 16'h100, dat(2, 0, 8'h00), 1, 1));
      push(0, wrd(16'h2000 + 16'(r) * 16'h100, dat(0, 0, 8'h00), 1, 1));
    end
    fork
      begin int x0; mtx(0, 16'h2000, 1, 1, x0); mtx(0, 16'h2100, 1, 1, x0); end
      begin int x1; mtx(1, 16'h2000, 1, 1, x1); mtx(1, 16'h2100, 1, 1, x1); end
      begin int x2; mtx(2, 16'h2000, 1, 1, x2); mtx(2, 16'h2100, 1, 1, x2); end
    join
    drained("R5 round robin order");

    // R8: stalled output port 2
    ordy[2] = 0;
    push(2, wrd(16'hA000, dat(2, 0, 8'h00), 1, 1));
    fork
      mtx(2, 16'hA000, 1, 1, w2);
      begin
        repeat (3) @(negedge clk);
        chk(out_vld[2] == 1 && in_rdy[2] == 0, "R8 stall holds word", {out_vld[2], in_rdy[2]}, 2'b10);
        repeat (2) @(negedge clk);
        chk(out_vld[2] == 1 && in_rdy[2] == 0, "R8 stall persists", {out_vld[2], in_rdy[2]}, 2'b10);
        @(posedge clk); #1 ordy[2] = 1;
      end
    join
    drained("R8 word delivered after stall");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule